// File: doc/BRIEF.md
# Background Tile Fetch Address Generator

This block produces the video-memory addresses that a background tile fetcher needs for one tile. It also captures the bytes that come back. A start pulse latches the map base, the tile column, the fetch row and the tile data base. The block then runs four fixed steps: index, data-low, data-high and push. Each step lasts `STEP_CYCLES` clocks. In every step it presents the address during the first cycle and samples the read data on the edge that ends the step.

The memory port is 16 bits wide. The low byte comes from bank 0 and the high byte from bank 1 at the same offset. In colour mode, one read in the index step therefore returns both the tile number and its attribute byte. Attribute bit 6 mirrors the tile vertically, so the row inside the tile is inverted before the data addresses are formed. While the port is blocked to the fetcher, every captured byte reads as all ones.

The address of the index fetch and the address of the data-high fetch are kept in registers and exported. Neighbouring logic that resolves processor accesses colliding with a fetch can use them.

Top module: `tile_addr_gen`

## Requirements
- R1: After reset, `lastIdxAddr` and `lastDataAddr` are 0, and `busy`, `done` and `vramRd` are low.
- R2: During the index step, `vramAddr` equals (mapBase + tileCol + (fetchRow >> 3) * 32) mod 8192 and `vramRd` is high. After that step, `lastIdxAddr` holds the same value.
- R3: In colour mode (`colorMode`=1), `tileAttr` is bits 15:8 and `tileIdx` is bits 7:0 of the single index-step read. In monochrome mode, `tileAttr` is 0.
- R4: While `blocked` is high, `tileIdx`, `dataLo` and `dataHi` capture 0xFF, and so does `tileAttr` in colour mode.
- R5: During the data-low step, `vramAddr` equals (dataBase + fine * 2) mod 8192. Here fine is fetchRow[2:0], XORed with 7 when bit 6 of the captured attribute is set. `dataLo` takes bits 7:0 of that read.
- R6: During the data-high step, `vramAddr` is the data-low address plus 1 (mod 8192). `dataHi` takes bits 7:0 of that read, and `lastDataAddr` holds that address afterwards.
- R7: With a start sampled on edge E0, the index, data-low and data-high steps begin right after E0, E2 and E4. `done` is high for exactly the one cycle after E8, and `busy` is high from E0 until E8.
- R8: `mapBase`, `tileCol`, `fetchRow` and `dataBase` are sampled only with the start. Later changes during a fetch do not alter any address or result of that fetch.
- R9: A start raised while `busy` is high is ignored, so `busy` stays low after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tile fetch (accepted only when idle) |
| mapBase | input | 13 | Tile map base offset |
| tileCol | input | 5 | Tile column within the map row |
| fetchRow | input | 8 | Pixel row being fetched |
| dataBase | input | 13 | Base offset of the tile's pattern data |
| colorMode | input | 1 | Capture the attribute byte from bank 1 |
| blocked | input | 1 | Memory unavailable to the fetcher; bytes read as 0xFF |
| vramAddr | output | 13 | Address presented to both banks |
| vramRd | output | 1 | Read request during fetch steps |
| vramData | input | 16 | Bank 1 byte in 15:8, bank 0 byte in 7:0 |
| tileIdx | output | 8 | Captured tile number |
| tileAttr | output | 8 | Captured attribute byte |
| dataLo | output | 8 | Captured low pattern byte |
| dataHi | output | 8 | Captured high pattern byte |
| lastIdxAddr | output | 13 | Address of the most recent index fetch |
| lastDataAddr | output | 13 | Address of the most recent data-high fetch |
| busy | output | 1 | A fetch is in progress |
| done | output | 1 | One-cycle pulse after the push step |

## Verification
A wrong step or phase shows at the ports as a `vramAddr` that does not match the expected step, or as a `done` pulse on the wrong edge. The sweep catches this within the first fetch after the fault. A wrongly captured attribute bit 6 alters the data-low address in the very next step, so a flip error shows two cycles after the index read. A stale sampled input or a bad latched address shows as a wrong `lastIdxAddr` or `lastDataAddr` right after the step that writes it. The sweep covers every fetch row in both modes, with and without blocking.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;

  typedef enum logic [2:0] {
    STEP_IDLE,
    STEP_INDEX,
    STEP_DATA_LO,
    STEP_DATA_HI,
    STEP_PUSH
  } stepT;

  typedef enum logic [1:0] {
    SEL_INDEX,
    SEL_DATA_LO,
    SEL_DATA_HI
  } addrSelT;

  // Strobes from control to datapath
  typedef struct packed {
    logic    load;    // sample request inputs
    logic    capIdx;  // end of index step
    logic    capLo;   // end of data-low step
    logic    capHi;   // end of data-high step
    logic    rd;      // read request
    addrSelT sel;     // address source
  } strobeT;

endpackage

// File: rtl/tile_addr_ctrl.sv
module tile_addr_ctrl
  import tile_addr_pkg::*;
#(
  parameter int STEP_CYCLES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  output strobeT strobe,
  output logic   busy,
  output logic   done
);
  localparam int PH_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(STEP_CYCLES - 1);

  stepT            step;
  logic [PH_W-1:0] phase;
  logic            lastPh;

  assign lastPh = (phase == PH_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step  <= STEP_IDLE;
      phase <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (step == STEP_IDLE) begin
        phase <= '0;
        if (start) step <= STEP_INDEX;
      end else if (lastPh) begin
        phase <= '0;
        unique case (step)
          STEP_INDEX:   step <= STEP_DATA_LO;
          STEP_DATA_LO: step <= STEP_DATA_HI;
          STEP_DATA_HI: step <= STEP_PUSH;
          default: begin
            step <= STEP_IDLE;
            done <= 1'b1;
          end
        endcase
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load   = (step == STEP_IDLE) && start;
    strobe.capIdx = (step == STEP_INDEX)   && lastPh;
    strobe.capLo  = (step == STEP_DATA_LO) && lastPh;
    strobe.capHi  = (step == STEP_DATA_HI) && lastPh;
    strobe.rd     = (step == STEP_INDEX) || (step == STEP_DATA_LO) ||
                    (step == STEP_DATA_HI);
    unique case (step)
      STEP_DATA_LO: strobe.sel = SEL_DATA_LO;
      STEP_DATA_HI: strobe.sel = SEL_DATA_HI;
      default:      strobe.sel = SEL_INDEX;
    endcase
  end

  assign busy = (step != STEP_IDLE);

endmodule

// File: rtl/tile_addr_dp.sv
module tile_addr_dp
  import tile_addr_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int COL_W         = 5,
  parameter int ROW_W         = 8,
  parameter int BYTE_W        = 8,
  parameter int MAP_COLS      = 32,
  parameter int TILE_ROWS     = 8,
  parameter int BYTES_PER_ROW = 2,
  parameter int FLIP_BIT      = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobe,
  input  logic [ADDR_W-1:0]   mapBase,
  input  logic [COL_W-1:0]    tileCol,
  input  logic [ROW_W-1:0]    fetchRow,
  input  logic [ADDR_W-1:0]   dataBase,
  input  logic                colorMode,
  input  logic                blocked,
  input  logic [2*BYTE_W-1:0] vramData,
  output logic [ADDR_W-1:0]   vramAddr,
  output logic [BYTE_W-1:0]   tileIdx,
  output logic [BYTE_W-1:0]   tileAttr,
  output logic [BYTE_W-1:0]   dataLo,
  output logic [BYTE_W-1:0]   dataHi,
  output logic [ADDR_W-1:0]   lastIdxAddr,
  output logic [ADDR_W-1:0]   lastDataAddr
);
  localparam int ROW_SHIFT    = $clog2(TILE_ROWS);
  localparam int MAP_SHIFT    = $clog2(MAP_COLS);
  localparam int STRIDE_SHIFT = $clog2(BYTES_PER_ROW);

  logic [ADDR_W-1:0]    mapQ, baseQ;
  logic [COL_W-1:0]     colQ;
  logic [ROW_W-1:0]     rowQ;
  logic [ROW_SHIFT-1:0] fine;
  logic [ADDR_W-1:0]    idxAddr, loAddr, hiAddr;
  logic [BYTE_W-1:0]    bank0, bank1;

  assign bank0 = blocked ? '1 : vramData[BYTE_W-1:0];
  assign bank1 = blocked ? '1 : vramData[2*BYTE_W-1:BYTE_W];

  assign idxAddr = mapQ + ADDR_W'(colQ) +
                   (ADDR_W'(rowQ >> ROW_SHIFT) << MAP_SHIFT);
  assign fine    = rowQ[ROW_SHIFT-1:0] ^ {ROW_SHIFT{tileAttr[FLIP_BIT]}};
  assign loAddr  = baseQ + (ADDR_W'(fine) << STRIDE_SHIFT);
  assign hiAddr  = loAddr + ADDR_W'(1);

  always_comb begin
    unique case (strobe.sel)
      SEL_DATA_LO: vramAddr = loAddr;
      SEL_DATA_HI: vramAddr = hiAddr;
      default:     vramAddr = idxAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapQ         <= '0;
      baseQ        <= '0;
      colQ         <= '0;
      rowQ         <= '0;
      tileIdx      <= '0;
      tileAttr     <= '0;
      dataLo       <= '0;
      dataHi       <= '0;
      lastIdxAddr  <= '0;
      lastDataAddr <= '0;
    end else begin
      if (strobe.load) begin
        mapQ  <= mapBase;
        baseQ <= dataBase;
        colQ  <= tileCol;
        rowQ  <= fetchRow;
      end
      if (strobe.capIdx) begin
        tileIdx     <= bank0;
        tileAttr    <= colorMode ? bank1 : '0;
        lastIdxAddr <= idxAddr;
      end
      if (strobe.capLo) dataLo <= bank0;
      if (strobe.capHi) begin
        dataHi       <= bank0;
        lastDataAddr <= hiAddr;
      end
    end
  end

endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tile_addr_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int COL_W       = 5,
  parameter int ROW_W       = 8,
  parameter int BYTE_W      = 8,
  parameter int STEP_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [ADDR_W-1:0]   mapBase,
  input  logic [COL_W-1:0]    tileCol,
  input  logic [ROW_W-1:0]    fetchRow,
  input  logic [ADDR_W-1:0]   dataBase,
  input  logic                colorMode,
  input  logic                blocked,
  output logic [ADDR_W-1:0]   vramAddr,
  output logic                vramRd,
  input  logic [2*BYTE_W-1:0] vramData,
  output logic [BYTE_W-1:0]   tileIdx,
  output logic [BYTE_W-1:0]   tileAttr,
  output logic [BYTE_W-1:0]   dataLo,
  output logic [BYTE_W-1:0]   dataHi,
  output logic [ADDR_W-1:0]   lastIdxAddr,
  output logic [ADDR_W-1:0]   lastDataAddr,
  output logic                busy,
  output logic                done
);
  strobeT strobe;

  tile_addr_ctrl #(.STEP_CYCLES(STEP_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobe(strobe), .busy(busy), .done(done)
  );

  tile_addr_dp #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .ROW_W(ROW_W), .BYTE_W(BYTE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .mapBase(mapBase), .tileCol(tileCol), .fetchRow(fetchRow),
    .dataBase(dataBase), .colorMode(colorMode), .blocked(blocked),
    .vramData(vramData), .vramAddr(vramAddr),
    .tileIdx(tileIdx), .tileAttr(tileAttr),
    .dataLo(dataLo), .dataHi(dataHi),
    .lastIdxAddr(lastIdxAddr), .lastDataAddr(lastDataAddr)
  );

  assign vramRd = strobe.rd;

endmodule

// File: rtl/tile_addr_chk.sv
module tile_addr_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              vramRd,
  input logic [ADDR_W-1:0] vramAddr,
  input logic [ADDR_W-1:0] lastIdxAddr,
  input logic [ADDR_W-1:0] lastDataAddr
);
  // R7: done is a single-cycle pulse and the fetcher is idle while it shows
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R7: reads only occur inside a fetch
  p_rd_in_fetch_r7: assert property (@(posedge clk) disable iff (!rstN)
    vramRd |-> busy);
  // R9: a fetch only begins from a start request
  p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  // R2: the latched index address is the one that was just presented
  p_idx_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lastIdxAddr) |-> (lastIdxAddr == $past(vramAddr)));
  // R6: the latched data address is the one that was just presented
  p_data_latch_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lastDataAddr) |-> (lastDataAddr == $past(vramAddr)));
endmodule

bind tile_addr_gen tile_addr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .vramRd(vramRd), .vramAddr(vramAddr),
  .lastIdxAddr(lastIdxAddr), .lastDataAddr(lastDataAddr)
);

// File: tb/tile_addr_gen_bench.sv
`timescale 1ns/1ps
module tile_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [12:0] mapBase = '0;
  logic [4:0]  tileCol = '0;
  logic [7:0]  fetchRow = '0;
  logic [12:0] dataBase = '0;
  logic        colorMode = 1'b0;
  logic        blocked = 1'b0;
  logic [12:0] vramAddr;
  logic        vramRd;
  logic [15:0] vramData;
  logic [7:0]  tileIdx, tileAttr, dataLo, dataHi;
  logic [12:0] lastIdxAddr, lastDataAddr;
  logic        busy, done;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  // Memory model: bank 0 and bank 1 contents are functions of the address
  function automatic logic [7:0] bank0F(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b000} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] bank1F(input logic [12:0] a);
    return {a[4:0], a[12:10]} ^ 8'hC3;
  endfunction
  assign vramData = {bank1F(vramAddr), bank0F(vramAddr)};

  tile_addr_gen u_tile_addr_gen (
    .clk(clk), .rstN(rstN), .start(start),
    .mapBase(mapBase), .tileCol(tileCol), .fetchRow(fetchRow),
    .dataBase(dataBase), .colorMode(colorMode), .blocked(blocked),
    .vramAddr(vramAddr), .vramRd(vramRd), .vramData(vramData),
    .tileIdx(tileIdx), .tileAttr(tileAttr), .dataLo(dataLo), .dataHi(dataHi),
    .lastIdxAddr(lastIdxAddr), .lastDataAddr(lastDataAddr),
    .busy(busy), .done(done)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  task automatic runFetch(input logic [12:0] mb, input logic [4:0] col,
                          input logic [7:0] row, input logic [12:0] db,
                          input logic cm, input logic blk);
    logic [12:0] expIdx, expLo, expHi;
    logic [7:0]  expTile, expAttr;
    logic [2:0]  fine;
    expIdx  = 13'((mb + col + (row >> 3) * 32) & 13'h1FFF);
    expTile = blk ? 8'hFF : bank0F(expIdx);
    expAttr = !cm ? 8'h00 : (blk ? 8'hFF : bank1F(expIdx));
    fine    = row[2:0] ^ (expAttr[6] ? 3'd7 : 3'd0);
    expLo   = 13'((db + fine * 2) & 13'h1FFF);
    expHi   = 13'((expLo + 1) & 13'h1FFF);

    mapBase = mb; tileCol = col; fetchRow = row; dataBase = db;
    colorMode = cm; blocked = blk; start = 1'b1;
    @(negedge clk);                                   // after E0
    start = 1'b0;
    chk(vramAddr, expIdx, "R2 index address");
    chk(vramRd, 1, "R2 read request");
    chk(busy, 1, "R7 busy after start");
    // R8: disturb request inputs after sampling
    mapBase = ~mb; tileCol = ~col; fetchRow = ~row; dataBase = ~db;
    @(negedge clk);
    @(negedge clk);                                   // after E2
    chk(tileIdx, expTile, blk ? "R4 blocked index" : "R3 tile index");
    chk(tileAttr, expAttr, blk ? "R4 blocked attr" : "R3 attribute");
    chk(lastIdxAddr, expIdx, "R2 latched index address R8");
    chk(vramAddr, expLo, "R5 data-low address R8");
    start = 1'b1;                                     // R9 start while busy
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);                                   // after E4
    chk(dataLo, blk ? 8'hFF : bank0F(expLo), "R5 data-low byte R4");
    chk(vramAddr, expHi, "R6 data-high address");
    @(negedge clk);
    @(negedge clk);                                   // after E6
    chk(dataHi, blk ? 8'hFF : bank0F(expHi), "R6 data-high byte R4");
    chk(lastDataAddr, expHi, "R6 latched data address");
    chk(vramRd, 0, "R7 no read in push");
    chk(done, 0, "R7 done early");
    @(negedge clk);
    chk(done, 0, "R7 done early");
    @(negedge clk);                                   // after E8
    chk(done, 1, "R7 done pulse");
    chk(busy, 0, "R7 busy ends");
    @(negedge clk);
    chk(done, 0, "R7 done width");
    chk(busy, 0, "R9 start during fetch ignored");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL R7 watchdog expired");
        finishRun();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(lastIdxAddr, 0, "R1 reset index address");
    chk(lastDataAddr, 0, "R1 reset data address");
    chk(busy, 0, "R1 reset busy");
    chk(done, 0, "R1 reset done");
    chk(vramRd, 0, "R1 reset read");
    rstN = 1'b1;
    @(negedge clk);
    for (int cm = 0; cm < 2; cm++) begin
      for (int blk = 0; blk < 2; blk++) begin
        for (int row = 0; row < 256; row++) begin
          runFetch(13'((13'h1800 + row * 37) & 13'h1FFF),
                   5'((row * 7 + cm) % 32), 8'(row),
                   13'((row * 53 + 13'h1F00) & 13'h1FFF),
                   1'(cm), 1'(blk));
        end
      end
    end
    finishRun();
  end
endmodule